// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a host write port and the embedded program/erase machinery of a NOR-style flash macro. It watches single-cycle write strobes, each carrying an address and a data word, and recognises multi-write command sequences. When a sequence completes, it emits a one-cycle start pulse together with the target address and data. The embedded algorithm answers with a `busy` level, and that level is the only view of it the decoder needs.

Every command opens with two unlock writes. Only the low twelve address bits of an unlock write are compared, so the unlock addresses may fall in any bank. The block also handles these operations:

- A single-cycle suspend and a single-cycle resume for a running erase.
- A window during which further sector erase requests are collected before the erase starts.
- A bypass mode in which a program needs only two writes.
- An identification mode that changes what reads return.

In identification mode, a read at a bank-relative offset returns a device code word or a sector lock flag in place of array data.

Top module: `flash_cmd_decoder`

## Requirements
- R1: An unlock pair is a write of data AAh followed by a write of data 55h. The first write must have address bits [11:0] equal to 555h and the second must have bits [11:0] equal to 2AAh. Address bits [20:12] are not compared. A first write with any other low address does not unlock.
- R2: Data A0h written after an unlock pair arms a program. The next write raises `op_prog` for exactly one cycle, in the cycle after that write, with `op_addr` and `op_data` equal to that write's address and data.
- R3: Writing 80h after an unlock pair, then a second unlock pair, then 10h at an address whose bits [11:0] are 555h raises `op_chip_erase` for one cycle, in the cycle after the last write.
- R4: In the same erase prefix, writing 30h raises `op_sect_mark` with `op_addr` set to that write's address. Each further 30h write is also accepted and restarts the window. `op_sect_erase` pulses exactly `WIN_CYC` cycles after the last accepted sector write. Any other write during the window abandons the erase, and no `op_sect_erase` follows.
- R5: A write that does not fit the sequence in progress returns the decoder to read-array state. After such a write, a data A0h write followed by an address/data write does not program.
- R6: Data 90h written after an unlock pair sets `id_mode`. While `id_mode` is set, `id_data` is decoded from the bank offset `rd_off`. Offset 00h gives 0001h and offset 01h gives 227Eh. With `TOP_BOOT`=1, offset 0Eh gives 2222h and offset 0Fh gives 2200h. With `TOP_BOOT`=0, offset 0Eh gives 2223h and offset 0Fh gives 2201h. Every other offset gives 0000h, and `id_data` is 0000h whenever `id_mode` is clear.
- R7: In identification mode, offset 02h returns 0001h when `sect_locked` is 1 and 0000h when it is 0.
- R8: A write of data F0h clears `id_mode`, bypass mode and any partial sequence. While `busy` is 1, F0h and every other write apart from suspend and resume have no effect.
- R9: Data B0h written while an erase is active and not suspended raises `op_suspend` for one cycle. Data 30h written while suspended raises `op_resume`. A further 30h write gives no pulse. A new B0h write is accepted after a resume. An erase stops being active when `busy` falls while the erase is not suspended.
- R10: Data 20h written after an unlock pair enters bypass mode. In bypass mode, A0h followed by an address/data write programs as in R2, with no unlock pair. Writing 90h and then 00h leaves bypass mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| busy | input | 1 | Embedded program/erase algorithm running |
| rd_off | input | OFF_W | Bank-relative offset of the current read |
| sect_locked | input | 1 | Lock state of the sector being read |
| op_prog | output | 1 | Program start pulse |
| op_chip_erase | output | 1 | Chip erase start pulse |
| op_sect_mark | output | 1 | Sector accepted for erase |
| op_sect_erase | output | 1 | Sector erase start pulse, issued after the window closes |
| op_suspend | output | 1 | Erase suspend pulse |
| op_resume | output | 1 | Erase resume pulse |
| op_addr | output | ADDR_W | Address attached to a program or sector pulse |
| op_data | output | DATA_W | Data attached to a program pulse |
| id_mode | output | 1 | Reads return identification data |
| id_data | output | DATA_W | Identification word for `rd_off` |

## Verification
A wrong sequence state shows up at the ports on the very next write of a sequence. Either a start pulse appears that should not, or an expected pulse is missing one cycle after the closing write. The bench therefore probes each state with both a matching write and a breaking write. A miscounted window moves `op_sect_erase` by whole cycles, so the bench counts the exact cycle of the pulse after the last sector write. A stale suspend flag or erase-active flag shows as a missing or extra `op_suspend`/`op_resume` pulse on the write that follows.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    S_READ, S_UNL1, S_UNL2, S_PROG, S_ERA1, S_ERA2, S_ERA3,
    S_WIN, S_BPROG, S_BEXIT
  } fcd_state_e;

  localparam logic [11:0] UNL_ADDR1 = 12'h555;
  localparam logic [11:0] UNL_ADDR2 = 12'h2AA;

  localparam logic [7:0] C_UNL1   = 8'hAA;
  localparam logic [7:0] C_UNL2   = 8'h55;
  localparam logic [7:0] C_PROG   = 8'hA0;
  localparam logic [7:0] C_ERASE  = 8'h80;
  localparam logic [7:0] C_CHIP   = 8'h10;
  localparam logic [7:0] C_SECT   = 8'h30;
  localparam logic [7:0] C_IDENT  = 8'h90;
  localparam logic [7:0] C_BYPASS = 8'h20;
  localparam logic [7:0] C_RESET  = 8'hF0;
  localparam logic [7:0] C_SUSP   = 8'hB0;
  localparam logic [7:0] C_BEXIT  = 8'h00;

  // Identification word for a bank offset
  function automatic logic [15:0] fcd_id_word(input logic [7:0] off,
                                              input logic locked,
                                              input logic top_boot);
    logic [15:0] w;
    case (off)
      8'h00:   w = 16'h0001;
      8'h01:   w = 16'h227E;
      8'h02:   w = {15'd0, locked};
      8'h0E:   w = top_boot ? 16'h2222 : 16'h2223;
      8'h0F:   w = top_boot ? 16'h2200 : 16'h2201;
      default: w = 16'h0000;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/fcd_win_timer.sv
module fcd_win_timer #(
  parameter int WIN_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic clear,
  output logic run,
  output logic expire
);
  localparam int CW = $clog2(WIN_CYC + 1);

  logic [CW-1:0] cnt;

  assign expire = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= CW'(WIN_CYC - 1);
      run <= 1'b1;
    end else if (clear || expire) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fcd_id_rom.sv
module fcd_id_rom
  import fcd_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int OFF_W    = 8,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              id_mode,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic              sect_locked,
  output logic [DATA_W-1:0] id_data
);
  logic [15:0] word;

  always_comb begin
    word    = fcd_id_word(8'(rd_off), sect_locked, TOP_BOOT);
    id_data = id_mode ? DATA_W'(word) : '0;
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
#(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int UNLOCK_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              win_expire,
  output logic              win_load,
  output logic              win_clear,
  output logic              in_window,
  output logic              susp,
  output logic              erase_act,
  output logic              op_prog,
  output logic              op_chip_erase,
  output logic              op_sect_mark,
  output logic              op_sect_erase,
  output logic              op_suspend,
  output logic              op_resume,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              id_mode
);
  fcd_state_e st;
  logic       bypass, busy_q;

  logic [7:0]          cmd;
  logic [UNLOCK_W-1:0] lo;
  logic                hit1, hit2, is_susp, is_resume, cmd_ok, is_reset;

  always_comb begin
    cmd       = wr_data[7:0];
    lo        = wr_addr[UNLOCK_W-1:0];
    hit1      = (lo == UNLOCK_W'(UNL_ADDR1)) && (cmd == C_UNL1);
    hit2      = (lo == UNLOCK_W'(UNL_ADDR2)) && (cmd == C_UNL2);
    is_susp   = wr_en && (cmd == C_SUSP) && erase_act && !susp;
    is_resume = wr_en && (cmd == C_SECT) && susp;
    cmd_ok    = wr_en && !is_susp && !is_resume && !busy;
    is_reset  = (cmd == C_RESET) && (st != S_PROG) && (st != S_BPROG);
    win_load  = cmd_ok && !is_reset && (cmd == C_SECT) &&
                ((st == S_ERA3) || (st == S_WIN));
    win_clear = cmd_ok && (st == S_WIN) && !win_load;
    in_window = (st == S_WIN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_READ;
      bypass        <= 1'b0;
      busy_q        <= 1'b0;
      susp          <= 1'b0;
      erase_act     <= 1'b0;
      id_mode       <= 1'b0;
      op_prog       <= 1'b0;
      op_chip_erase <= 1'b0;
      op_sect_mark  <= 1'b0;
      op_sect_erase <= 1'b0;
      op_suspend    <= 1'b0;
      op_resume     <= 1'b0;
      op_addr       <= '0;
      op_data       <= '0;
    end else begin
      busy_q        <= busy;
      op_prog       <= 1'b0;
      op_chip_erase <= 1'b0;
      op_sect_mark  <= 1'b0;
      op_sect_erase <= 1'b0;
      op_suspend    <= 1'b0;
      op_resume     <= 1'b0;
      if (busy_q && !busy && !susp) erase_act <= 1'b0;

      if (is_susp) begin
        op_suspend <= 1'b1;
        susp       <= 1'b1;
      end else if (is_resume) begin
        op_resume <= 1'b1;
        susp      <= 1'b0;
      end else if (cmd_ok && is_reset) begin
        st      <= S_READ;
        id_mode <= 1'b0;
        bypass  <= 1'b0;
      end else if (cmd_ok) begin
        st <= S_READ;
        unique case (st)
          S_READ: begin
            if (bypass) begin
              if (cmd == C_PROG)       st <= S_BPROG;
              else if (cmd == C_IDENT) st <= S_BEXIT;
            end else if (hit1) st <= S_UNL1;
          end
          S_UNL1: if (hit2) st <= S_UNL2;
          S_UNL2: begin
            if (cmd == C_PROG)        st <= S_PROG;
            else if (cmd == C_ERASE)  st <= S_ERA1;
            else if (cmd == C_IDENT)  id_mode <= 1'b1;
            else if (cmd == C_BYPASS) bypass <= 1'b1;
          end
          S_PROG, S_BPROG: begin
            op_prog <= 1'b1;
            op_addr <= wr_addr;
            op_data <= wr_data;
          end
          S_ERA1: if (hit1) st <= S_ERA2;
          S_ERA2: if (hit2) st <= S_ERA3;
          S_ERA3, S_WIN: begin
            if (win_load) begin
              st           <= S_WIN;
              op_sect_mark <= 1'b1;
              op_addr      <= wr_addr;
            end else if ((st == S_ERA3) && (cmd == C_CHIP) &&
                         (lo == UNLOCK_W'(UNL_ADDR1))) begin
              op_chip_erase <= 1'b1;
              erase_act     <= 1'b1;
            end
          end
          S_BEXIT: if (cmd == C_BEXIT) bypass <= 1'b0;
          default: st <= S_READ;
        endcase
      end else if ((st == S_WIN) && win_expire) begin
        st            <= S_READ;
        op_sect_erase <= 1'b1;
        erase_act     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W   = 21,
  parameter int DATA_W   = 16,
  parameter int OFF_W    = 8,
  parameter int UNLOCK_W = 12,
  parameter int WIN_CYC  = 8,
  parameter bit TOP_BOOT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic [OFF_W-1:0]  rd_off,
  input  logic              sect_locked,
  output logic              op_prog,
  output logic              op_chip_erase,
  output logic              op_sect_mark,
  output logic              op_sect_erase,
  output logic              op_suspend,
  output logic              op_resume,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              id_mode,
  output logic [DATA_W-1:0] id_data
);
  logic win_load, win_clear, win_expire, win_run, in_window;
  logic susp, erase_act;

  fcd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .UNLOCK_W(UNLOCK_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .win_expire(win_expire),
    .win_load(win_load), .win_clear(win_clear), .in_window(in_window),
    .susp(susp), .erase_act(erase_act), .op_prog(op_prog),
    .op_chip_erase(op_chip_erase), .op_sect_mark(op_sect_mark),
    .op_sect_erase(op_sect_erase), .op_suspend(op_suspend),
    .op_resume(op_resume), .op_addr(op_addr), .op_data(op_data),
    .id_mode(id_mode)
  );

  fcd_win_timer #(.WIN_CYC(WIN_CYC)) u_win (
    .clk(clk), .rst_n(rst_n), .load(win_load), .clear(win_clear),
    .run(win_run), .expire(win_expire)
  );

  fcd_id_rom #(.DATA_W(DATA_W), .OFF_W(OFF_W), .TOP_BOOT(TOP_BOOT)) u_id (
    .id_mode(id_mode), .rd_off(rd_off), .sect_locked(sect_locked),
    .id_data(id_data)
  );
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic              busy,
  input logic              op_prog,
  input logic              op_chip_erase,
  input logic              op_sect_mark,
  input logic              op_sect_erase,
  input logic              op_suspend,
  input logic              op_resume,
  input logic              id_mode,
  input logic [DATA_W-1:0] id_data,
  input logic              win_run,
  input logic              in_window,
  input logic              susp,
  input logic              erase_act
);
  p_prog_from_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_prog |-> $past(wr_en));

  p_chip_from_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_chip_erase |-> $past(wr_en) && ($past(wr_data[7:0]) == 8'h10));

  p_mark_from_30_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_sect_mark |-> $past(wr_en) && ($past(wr_data[7:0]) == 8'h30));

  p_erase_after_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_sect_erase |-> $past(win_run) && $past(in_window));

  p_id_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !id_mode |-> (id_data == '0));

  p_busy_keeps_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && id_mode) |=> id_mode);

  p_resume_needs_susp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_resume |-> $past(susp));

  p_susp_needs_erase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_suspend |-> $past(erase_act) && !$past(susp));

  p_single_op_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_prog, op_chip_erase, op_sect_mark, op_sect_erase,
              op_suspend, op_resume}));
endmodule

bind flash_cmd_decoder fcd_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .busy(busy),
  .op_prog(op_prog), .op_chip_erase(op_chip_erase),
  .op_sect_mark(op_sect_mark), .op_sect_erase(op_sect_erase),
  .op_suspend(op_suspend), .op_resume(op_resume), .id_mode(id_mode),
  .id_data(id_data), .win_run(win_run), .in_window(in_window),
  .susp(susp), .erase_act(erase_act)
);

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int WIN = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, busy = 1'b0, sect_locked = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [7:0] rd_off = '0;
  logic op_prog, op_chip_erase, op_sect_mark, op_sect_erase, op_suspend, op_resume;
  logic [AW-1:0] op_addr;
  logic [DW-1:0] op_data, id_data;
  logic id_mode;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic s_prog, s_chip, s_mark, s_serase, s_susp, s_res;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .rd_off(rd_off),
    .sect_locked(sect_locked), .op_prog(op_prog),
    .op_chip_erase(op_chip_erase), .op_sect_mark(op_sect_mark),
    .op_sect_erase(op_sect_erase), .op_suspend(op_suspend),
    .op_resume(op_resume), .op_addr(op_addr), .op_data(op_data),
    .id_mode(id_mode), .id_data(id_data)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    s_prog = op_prog; s_chip = op_chip_erase; s_mark = op_sect_mark;
    s_serase = op_sect_erase; s_susp = op_suspend; s_res = op_resume;
  endtask

  task automatic unlock(input logic [AW-1:0] up);
    wr(up | 21'h555, 16'h00AA);
    wr(up | 21'h2AA, 16'h0055);
  endtask

  function automatic logic [15:0] exp_id(input int off, input bit lk);
    if (off == 0) return 16'h0001;
    if (off == 1) return 16'h227E;
    if (off == 2) return lk ? 16'h0001 : 16'h0000;
    if (off == 14) return 16'h2222;
    if (off == 15) return 16'h2200;
    return 16'h0000;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int k;
    repeat (3) @(negedge clk);
    chk(op_prog == 0 && op_chip_erase == 0 && op_sect_erase == 0 && id_mode == 0,
        "reset outputs idle", {op_prog, op_chip_erase, op_sect_erase, id_mode}, 0);
    rst_n = 1'b1;

    // R1 R2: unlock with every upper address bit, then program
    for (int i = 0; i < 9; i++) begin
      logic [AW-1:0] up, pa;
      up = AW'(1) << (12 + i);
      pa = AW'(i * 4097 + 3);
      unlock(up);
      wr(up, 16'h00A0);
      chk(s_prog == 0, "R2 no pulse on A0", s_prog, 0);
      wr(pa, 16'h1234 + 16'(i));
      chk(s_prog == 1, "R1 R2 prog pulse", s_prog, 1);
      chk(op_addr == pa && op_data == 16'h1234 + 16'(i), "R2 addr/data",
          {op_addr, op_data}, {pa, 16'h1234 + 16'(i)});
      @(negedge clk);
      chk(op_prog == 0, "R2 pulse one cycle", op_prog, 0);
    end

    // R1 negative: wrong low address
    wr(21'h554, 16'h00AA); wr(21'h2AA, 16'h0055); wr(0, 16'h00A0); wr(21'h40, 16'h5555);
    chk(s_prog == 0, "R1 wrong unlock address", s_prog, 0);

    // R5: break the sequence
    unlock(0); wr(21'h100, 16'h0077); wr(0, 16'h00A0); wr(21'h41, 16'h6666);
    chk(s_prog == 0, "R5 mismatch returns to read", s_prog, 0);

    // R3 chip erase
    unlock(0); wr(0, 16'h0080); unlock(21'h1000); wr(21'h3555, 16'h0010);
    chk(s_chip == 1, "R3 chip erase pulse", s_chip, 1);
    busy = 1'b1;
    // R9 suspend/resume
    wr(0, 16'h00B0);
    chk(s_susp == 1, "R9 suspend", s_susp, 1);
    wr(0, 16'h0030);
    chk(s_res == 1, "R9 resume", s_res, 1);
    wr(0, 16'h0030);
    chk(s_res == 0, "R9 second resume ignored", s_res, 0);
    wr(0, 16'h00B0);
    chk(s_susp == 1, "R9 suspend again", s_susp, 1);
    wr(0, 16'h0030);
    chk(s_res == 1, "R9 resume again", s_res, 1);
    @(negedge clk); busy = 1'b0; @(negedge clk);
    wr(0, 16'h00B0);
    chk(s_susp == 0, "R9 no suspend when erase ended", s_susp, 0);

    // R8 reset blocked while busy
    unlock(0); wr(0, 16'h0090);
    chk(id_mode == 1, "R6 enter id mode", id_mode, 1);
    busy = 1'b1;
    wr(0, 16'h00F0);
    chk(id_mode == 1, "R8 reset ignored while busy", id_mode, 1);
    busy = 1'b0;

    // R6 R7 id sweep
    for (int off = 0; off < 16; off++) begin
      for (int lk = 0; lk < 2; lk++) begin
        @(negedge clk);
        rd_off = 8'(off); sect_locked = lk[0];
        #1;
        chk(id_data == exp_id(off, lk[0]), "R6 R7 id word", id_data, exp_id(off, lk[0]));
      end
    end
    wr(0, 16'h00F0);
    chk(id_mode == 0, "R8 reset leaves id mode", id_mode, 0);
    #1;
    chk(id_data == 0, "R6 id data quiet", id_data, 0);

    // R4 sector erase window
    unlock(0); wr(0, 16'h0080); unlock(0);
    wr(21'h08123, 16'h0030);
    chk(s_mark == 1 && op_addr == 21'h08123, "R4 first sector", op_addr, 21'h08123);
    repeat (3) @(negedge clk);
    wr(21'h18000, 16'h0030);
    chk(s_mark == 1 && op_addr == 21'h18000, "R4 second sector", op_addr, 21'h18000);
    k = 0;
    for (int c = 1; c <= WIN + 4; c++) begin
      @(negedge clk);
      if (op_sect_erase && k == 0) k = c;
    end
    chk(k == WIN, "R4 window length", k, WIN);
    busy = 1'b1; @(negedge clk); busy = 1'b0; @(negedge clk);

    // R4 abandon
    unlock(0); wr(0, 16'h0080); unlock(0); wr(21'h20000, 16'h0030);
    wr(0, 16'h0012);
    k = 0;
    for (int c = 1; c <= WIN + 4; c++) begin
      @(negedge clk);
      if (op_sect_erase) k = c;
    end
    chk(k == 0, "R4 abandoned window no erase", k, 0);

    // R8 partial sequence reset
    unlock(0); wr(0, 16'h00F0); wr(0, 16'h00A0); wr(21'h55, 16'h1111);
    chk(s_prog == 0, "R8 reset clears partial", s_prog, 0);

    // R10 bypass
    unlock(0); wr(0, 16'h0020);
    for (int j = 0; j < 3; j++) begin
      wr(0, 16'h00A0);
      wr(21'h700 + AW'(j), 16'hBEE0 + 16'(j));
      chk(s_prog == 1 && op_addr == 21'h700 + AW'(j) && op_data == 16'hBEE0 + 16'(j),
          "R10 bypass program", {s_prog, op_addr}, {1'b1, 21'h700 + AW'(j)});
    end
    wr(0, 16'h0090); wr(0, 16'h0000);
    wr(0, 16'h00A0); wr(21'h900, 16'h2222);
    chk(s_prog == 0, "R10 bypass exit", s_prog, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule